// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block is the datapath of a single DMA channel. It holds a page value, a 16-bit current address with its base copy, and a 16-bit current count with its base copy. Each accepted transfer strobe presents a 24-bit physical bus address. After the strobe the block steps the address, decrements the count and flags terminal count on the last transfer. The host loads page, address, count and mode through strobed load inputs. The block reports the remaining transfer size in bytes as a residue.

A build-time parameter selects one of two channel types. A byte channel moves bytes inside a 64K window. A word channel moves 16-bit words inside a 128K window, and its address is shifted left by one bit. The page is never incremented by the datapath, so a transfer wraps inside its window and does not cross into the next page. With auto-initialise set, the channel reloads address and count from the base copies at terminal count and stays open. Without it, the channel masks itself.

Top module: `dma_addr_gen`

## Requirements
- R1: On a byte channel (WORD_CH=0), phys_addr[23:16] is the page and phys_addr[15:0] is the current address. odd_lane equals address bit 0 and word_xfer is 0.
- R2: On a word channel (WORD_CH=1), phys_addr[16:1] is the current address, phys_addr[0] is 0 and phys_addr[23:17] is page bits 7:1. Page bit 0 has no effect, odd_lane is 0 and word_xfer is 1.
- R3: The address counter wraps from 0xFFFF to 0x0000 (or from 0x0000 to 0xFFFF when decrementing) without changing the page bits of phys_addr.
- R4: An accepted strobe (xfer high, masked low, no load in that cycle) steps the address by +1, or by -1 when mode_dec was loaded as 1. It also lowers the count by one.
- R5: A loaded count N gives exactly N+1 accepted transfers before terminal count. A loaded 0x0000 means one transfer and 0xFFFF means 65536.
- R6: residue is (count+1) mod 65536. On a word channel this value is doubled to give bytes, in 17 bits.
- R7: tc is high during the accepted strobe in which the count is 0x0000. Without auto-initialise, the channel then sets masked, and its residue reads zero.
- R8: With mode_auto loaded as 1, terminal count reloads the current address and count from the values last loaded by the host, and masked stays low.
- R9: While masked is high, xfer has no effect on phys_addr or residue. mask_clr clears masked and mask_set sets it. mask_set wins if both are high.
- R10: Any host load (ld_addr, ld_cnt, ld_page, ld_mode) in the same cycle as xfer takes the loaded value, and the strobe is dropped.
- R11: After reset the channel is masked, address, count and page are zero, and auto-initialise and decrement are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_addr | input | 1 | Load host_data into base and current address |
| ld_cnt | input | 1 | Load host_data into base and current count |
| ld_page | input | 1 | Load host_data[7:0] into page |
| ld_mode | input | 1 | Load mode_auto and mode_dec |
| host_data | input | 16 | Host load value |
| mode_auto | input | 1 | Auto-initialise value for ld_mode |
| mode_dec | input | 1 | Decrement value for ld_mode |
| mask_set | input | 1 | Mask the channel |
| mask_clr | input | 1 | Unmask the channel |
| xfer | input | 1 | Transfer strobe |
| phys_addr | output | 24 | Physical address of the present transfer |
| odd_lane | output | 1 | Byte channel: odd byte lane |
| word_xfer | output | 1 | Channel moves 16-bit words |
| tc | output | 1 | Terminal count, during the last accepted strobe |
| masked | output | 1 | Channel mask state |
| residue | output | 17 | Remaining transfer size in bytes |

## Verification
The bench aims at the window edges. A byte address at 0xFFFF and a word address at 0xFFFF must both roll over to zero with the page unchanged. A design that carried into the page would move the transfer into the next 64K or 128K region. The count is checked at its ends. A load of 2 must raise tc on exactly the third strobe, and a load of 0xFFFE on a word channel must give a residue of 0x1FFFE; an off-by-one design would end a transfer early or late. The bench also checks an odd page on a word channel, strobes while masked and strobes that coincide with a host load. A wrong design would set address bit 0, move a masked channel, or lose the loaded value.

// File: rtl/dma_ag_pkg.sv
// Package: shared widths and the channel mode record.
package dma_ag_pkg;
    localparam int PHYS_W = 24;

    typedef struct packed {
        logic auto_init;  // reload from base copies at terminal count
        logic dec;        // step address downward
    } chan_mode_t;
endpackage

// File: rtl/dma_ag_addr_ctr.sv
// Address counter with base copy.
// Assumes the caller gives step only for an accepted transfer. reload is
// only meaningful together with step. load has priority over everything.
module dma_ag_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          dec,
    input  logic          reload,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] base;

    // Base copy: changes only on a host load.
    always_ff @(posedge clk) begin
        if (!rst_n)    base <= '0;
        else if (load) base <= load_val;
    end

    // Current address: load, reload at terminal count, or wrap-around step.
    always_ff @(posedge clk) begin
        if (!rst_n)               cur <= '0;
        else if (load)            cur <= load_val;
        else if (step && reload)  cur <= base;
        else if (step && dec)     cur <= cur - AW'(1);
        else if (step)            cur <= cur + AW'(1);
    end
endmodule

// File: rtl/dma_ag_cnt_ctr.sv
// Transfer counter with base copy. It holds transfers minus one and counts
// down, wrapping at zero. last is high while the count is zero, so the next
// accepted step is the final transfer.
module dma_ag_cnt_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic          reload,
    output logic [CW-1:0] cur,
    output logic          last
);
    logic [CW-1:0] base;

    // Base copy: changes only on a host load.
    always_ff @(posedge clk) begin
        if (!rst_n)    base <= '0;
        else if (load) base <= load_val;
    end

    // Current count: load, reload at terminal count, or decrement with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              cur <= '0;
        else if (load)           cur <= load_val;
        else if (step && reload) cur <= base;
        else if (step)           cur <= cur - CW'(1);
    end

    // Last-transfer flag: count at zero.
    always_comb last = (cur == '0);
endmodule

// File: rtl/dma_ag_phys_map.sv
// Forms the physical address, lane indication and byte residue from the
// page, address and count. The WORD_CH parameter picks the byte or word
// mapping. Purely combinational.
module dma_ag_phys_map
    import dma_ag_pkg::*;
#(
    parameter bit WORD_CH = 1'b0,
    parameter int AW      = 16,
    parameter int PW      = 8
) (
    input  logic [PW-1:0]     page,
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     cnt,
    output logic [PHYS_W-1:0] phys,
    output logic              odd_lane,
    output logic [AW:0]       residue
);
    logic [AW-1:0] units_left;

    // Remaining transfers, with wrap so a finished channel reads zero.
    always_comb units_left = cnt + AW'(1);

    generate
        if (WORD_CH) begin : g_word
            // Word mapping: address shifted up one, page bit 0 dropped.
            always_comb begin
                phys     = {page[PW-1:1], addr, 1'b0};
                odd_lane = 1'b0;
                residue  = {units_left, 1'b0};
            end
        end else begin : g_byte
            // Byte mapping: page above the address, lane from bit 0.
            always_comb begin
                phys     = {page, addr};
                odd_lane = addr[0];
                residue  = {1'b0, units_left};
            end
        end
    endgenerate
endmodule

// File: rtl/dma_addr_gen.sv
// One DMA channel's address and count datapath. It holds page, mode and
// mask and connects the address counter, the count counter and the physical
// mapper. Assumes the host does not strobe xfer while it is reprogramming;
// if it does, the load wins and the strobe is dropped.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter bit WORD_CH = 1'b0,
    parameter int AW      = 16,
    parameter int PW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              ld_page,
    input  logic              ld_mode,
    input  logic [AW-1:0]     host_data,
    input  logic              mode_auto,
    input  logic              mode_dec,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic              xfer,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              odd_lane,
    output logic              word_xfer,
    output logic              tc,
    output logic              masked,
    output logic [AW:0]       residue
);
    logic          ld_any;
    logic          xfer_ok;
    logic          cnt_last;
    logic          do_reload;
    logic [PW-1:0] page_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] cnt_q;
    chan_mode_t    mode_q;

    // Strobe acceptance: unmasked and no host load this cycle.
    always_comb begin
        ld_any    = ld_addr | ld_cnt | ld_page | ld_mode;
        xfer_ok   = xfer & ~masked & ~ld_any;
        tc        = xfer_ok & cnt_last;
        do_reload = mode_q.auto_init;
        word_xfer = WORD_CH;
    end

    // Page register: host writes only, never carried into.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (ld_page) page_q <= host_data[PW-1:0];
    end

    // Mode register: auto-initialise and direction.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (ld_mode) mode_q <= '{auto_init: mode_auto, dec: mode_dec};
    end

    // Mask: set by host or by terminal count without auto-initialise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    masked <= 1'b1;
        else if (mask_set || (tc && !mode_q.auto_init)) masked <= 1'b1;
        else if (mask_clr)                             masked <= 1'b0;
    end

    dma_ag_addr_ctr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val (host_data),
        .step     (xfer_ok),
        .dec      (mode_q.dec),
        .reload   (tc & do_reload),
        .cur      (addr_q)
    );

    dma_ag_cnt_ctr #(.CW(AW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_cnt),
        .load_val (host_data),
        .step     (xfer_ok),
        .reload   (tc & do_reload),
        .cur      (cnt_q),
        .last     (cnt_last)
    );

    dma_ag_phys_map #(.WORD_CH(WORD_CH), .AW(AW), .PW(PW)) u_map (
        .page     (page_q),
        .addr     (addr_q),
        .cnt      (cnt_q),
        .phys     (phys_addr),
        .odd_lane (odd_lane),
        .residue  (residue)
    );
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Checker for dma_addr_gen, bound to every instance. Watches ports and the
// loaded mode over time.
module dma_addr_gen_chk #(
    parameter bit WORD_CH = 1'b0,
    parameter int AW      = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_addr,
    input logic          ld_cnt,
    input logic          ld_page,
    input logic          ld_mode,
    input logic          mask_set,
    input logic          xfer,
    input logic [23:0]   phys_addr,
    input logic          tc,
    input logic          masked,
    input logic          auto_q,
    input logic [AW:0]   residue
);
    localparam int PG_LO = WORD_CH ? AW + 1 : AW;
    localparam logic [AW:0] ONE_UNIT = WORD_CH ? (AW+1)'(2) : (AW+1)'(1);

    logic ld_any;
    always_comb ld_any = ld_addr | ld_cnt | ld_page | ld_mode;

    // R3: page bits move only on a page load.
    a_r3_page_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_page |=> $stable(phys_addr[23:PG_LO]));

    // R9: a masked channel holds still without host loads.
    a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !ld_any) |=> ($stable(phys_addr) && $stable(residue)));

    // R7: terminal count only on an accepted strobe.
    a_r7_tc_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (xfer && !masked && !ld_any));

    // R6: at terminal count exactly one unit remains.
    a_r6_tc_residue: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (residue == ONE_UNIT));

    // R7: terminal count without auto-initialise masks the channel.
    a_r7_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !auto_q) |=> masked);

    // R8: terminal count with auto-initialise keeps the channel open.
    a_r8_auto_open: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && auto_q && !mask_set) |=> !masked);

    generate
        if (WORD_CH) begin : g_even
            // R2: word addresses are always even.
            a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
                phys_addr[0] == 1'b0);
        end
    endgenerate
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.WORD_CH(WORD_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .ld_page   (ld_page),
    .ld_mode   (ld_mode),
    .mask_set  (mask_set),
    .xfer      (xfer),
    .phys_addr (phys_addr),
    .tc        (tc),
    .masked    (masked),
    .auto_q    (mode_q.auto_init),
    .residue   (residue)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // Shared host drive; sel_word routes the strobes to the word channel.
    logic        sel_word = 1'b0;
    logic        ld_addr = 0, ld_cnt = 0, ld_page = 0, ld_mode = 0;
    logic [15:0] host_data = '0;
    logic        mode_auto = 0, mode_dec = 0, mask_set = 0, mask_clr = 0, xfer = 0;

    logic [23:0] pa_b, pa_w;
    logic        odd_b, odd_w, wx_b, wx_w, tc_b, tc_w, m_b, m_w;
    logic [16:0] res_b, res_w;

    dma_addr_gen #(.WORD_CH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr & ~sel_word), .ld_cnt(ld_cnt & ~sel_word),
        .ld_page(ld_page & ~sel_word), .ld_mode(ld_mode & ~sel_word),
        .host_data(host_data), .mode_auto(mode_auto), .mode_dec(mode_dec),
        .mask_set(mask_set & ~sel_word), .mask_clr(mask_clr & ~sel_word),
        .xfer(xfer & ~sel_word),
        .phys_addr(pa_b), .odd_lane(odd_b), .word_xfer(wx_b), .tc(tc_b),
        .masked(m_b), .residue(res_b));

    dma_addr_gen #(.WORD_CH(1'b1)) uut_word (
        .clk(clk), .rst_n(rst_n),
        .ld_addr(ld_addr & sel_word), .ld_cnt(ld_cnt & sel_word),
        .ld_page(ld_page & sel_word), .ld_mode(ld_mode & sel_word),
        .host_data(host_data), .mode_auto(mode_auto), .mode_dec(mode_dec),
        .mask_set(mask_set & sel_word), .mask_clr(mask_clr & sel_word),
        .xfer(xfer & sel_word),
        .phys_addr(pa_w), .odd_lane(odd_w), .word_xfer(wx_w), .tc(tc_w),
        .masked(m_w), .residue(res_w));

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        check(act == exp, req, act, exp);
    endtask

    // One host operation lasting a single cycle, driven on the falling edge.
    task automatic host_load(input int kind, input logic [15:0] v);
        @(negedge clk);
        host_data = v;
        case (kind)
            0: ld_addr = 1;
            1: ld_cnt  = 1;
            2: ld_page = 1;
            3: ld_mode = 1;
            4: mask_clr = 1;
            default: mask_set = 1;
        endcase
        @(negedge clk);
        {ld_addr, ld_cnt, ld_page, ld_mode, mask_clr, mask_set} = '0;
    endtask

    task automatic set_mode(input logic a, input logic d);
        mode_auto = a;
        mode_dec  = d;
        host_load(3, 16'h0);
    endtask

    // One strobe; returns the terminal-count level seen during it.
    task automatic strobe(output logic tc_seen);
        @(negedge clk);
        xfer = 1;
        #1 tc_seen = sel_word ? tc_w : tc_b;
        @(negedge clk);
        xfer = 0;
    endtask

    task automatic t_reset();
        chk_eq("R11 reset masked", m_b, 1);
        chk_eq("R11 reset addr", pa_b, 0);
        chk_eq("R11 reset residue byte", res_b, 1);
        chk_eq("R11 reset residue word", res_w, 2);
        chk_eq("R1 word_xfer byte", wx_b, 0);
        chk_eq("R2 word_xfer word", wx_w, 1);
    endtask

    task automatic t_map();
        sel_word = 0;
        host_load(2, 16'h0012);
        host_load(0, 16'h3457);
        chk_eq("R1 byte map", pa_b, 24'h123457);
        chk_eq("R1 odd lane", odd_b, 1);
        sel_word = 1;
        host_load(2, 16'h0013);
        host_load(0, 16'h3457);
        chk_eq("R2 word map odd page", pa_w, 24'h1268AE);
        chk_eq("R2 word lane", odd_w, 0);
    endtask

    task automatic t_wrap();
        logic t;
        sel_word = 0;
        set_mode(0, 0);
        host_load(2, 16'h0005);
        host_load(0, 16'hFFFF);
        host_load(1, 16'h0003);
        host_load(4, 16'h0);
        strobe(t);
        chk_eq("R3 byte wrap keeps page", pa_b, 24'h050000);
        chk_eq("R4 count step", res_b, 3);
        sel_word = 1;
        set_mode(0, 0);
        host_load(2, 16'h0005);
        host_load(0, 16'hFFFF);
        host_load(1, 16'h0003);
        host_load(4, 16'h0);
        chk_eq("R2 word before wrap", pa_w, 24'h05FFFE);
        strobe(t);
        chk_eq("R3 word wrap keeps page", pa_w, 24'h040000);
    endtask

    task automatic t_count_tc();
        logic t0, t1, t2;
        sel_word = 0;
        set_mode(0, 0);
        host_load(2, 16'h0000);
        host_load(0, 16'h0100);
        host_load(1, 16'h0002);
        host_load(4, 16'h0);
        chk_eq("R6 residue after load", res_b, 3);
        strobe(t0);
        strobe(t1);
        strobe(t2);
        chk_eq("R5 no tc on first", t0, 0);
        chk_eq("R5 no tc on second", t1, 0);
        chk_eq("R7 tc on third", t2, 1);
        chk_eq("R7 masked after tc", m_b, 1);
        chk_eq("R7 residue zero", res_b, 0);
        chk_eq("R4 address after three", pa_b, 24'h000103);
        strobe(t0);
        chk_eq("R9 masked strobe addr", pa_b, 24'h000103);
        chk_eq("R9 masked strobe residue", res_b, 0);
        chk_eq("R9 masked strobe no tc", t0, 0);
    endtask

    task automatic t_dec();
        logic t;
        sel_word = 0;
        set_mode(0, 1);
        host_load(0, 16'h0010);
        host_load(1, 16'h0005);
        host_load(4, 16'h0);
        strobe(t);
        strobe(t);
        chk_eq("R4 decrement addr", pa_b, 24'h00000E);
        chk_eq("R4 decrement count", res_b, 4);
        host_load(0, 16'h0000);
        strobe(t);
        chk_eq("R3 down wrap keeps page", pa_b, 24'h00FFFF);
    endtask

    task automatic t_auto();
        logic t0, t1;
        sel_word = 0;
        set_mode(1, 0);
        host_load(0, 16'h2000);
        host_load(1, 16'h0001);
        host_load(4, 16'h0);
        strobe(t0);
        chk_eq("R4 auto first step", pa_b, 24'h002001);
        strobe(t1);
        chk_eq("R8 tc on second", t1, 1);
        chk_eq("R8 addr reloaded", pa_b, 24'h002000);
        chk_eq("R8 count reloaded", res_b, 2);
        chk_eq("R8 still open", m_b, 0);
    endtask

    task automatic t_priority();
        sel_word = 0;
        @(negedge clk);
        host_data = 16'h4444;
        ld_addr = 1;
        xfer = 1;
        @(negedge clk);
        ld_addr = 0;
        xfer = 0;
        chk_eq("R10 load wins addr", pa_b, 24'h004444);
        chk_eq("R10 strobe dropped count", res_b, 2);
        @(negedge clk);
        mask_set = 1;
        mask_clr = 1;
        @(negedge clk);
        {mask_set, mask_clr} = '0;
        chk_eq("R9 set beats clear", m_b, 1);
    endtask

    task automatic t_word_count();
        logic t;
        sel_word = 1;
        set_mode(0, 0);
        host_load(1, 16'hFFFE);
        chk_eq("R6 word residue max", res_w, 17'h1FFFE);
        host_load(1, 16'hFFFF);
        chk_eq("R6 full count wraps", res_w, 0);
        host_load(1, 16'h0009);
        chk_eq("R6 word residue bytes", res_w, 20);
        host_load(1, 16'h0000);
        host_load(4, 16'h0);
        strobe(t);
        chk_eq("R5 single transfer tc", t, 1);
        chk_eq("R7 word masked", m_w, 1);
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_map();
        t_wrap();
        t_count_tc();
        t_dec();
        t_auto();
        t_priority();
        t_word_count();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule